// File: doc/BRIEF.md
# Cascaded Search Result Arbiter

A table of search entries can be spread over a chain of up to 31 search devices. Each device compares the key against its own slice and reports a hit flag and a local match address. This block merges those per-device reports into one global answer. It picks the owner of the shared SRAM address bus and the owner of the shared hit/valid status flags, and it emits the result in a fixed cycle after the search command.

Device number gives the priority. A lower-numbered device holds lower table addresses, so the lowest-numbered hitting device wins. The winner's index, placed above its local address, forms the global address. When no device hits, two per-device flags pick the default drivers. A last-RAM flag picks the driver of the SRAM bus and a last-device flag picks the driver of the status flags. The bus ownership is modelled as one-hot drive-enable vectors. The result latency comes from the table-size code. The status flags trail the address by a further hit-latency delay. Both codes are taken from device 0. A registered error output reports any configuration that breaks the cascade rules.

Top module: `cas_result_arb`

## Requirements
- R1: When several devices hit, the lowest-numbered hitting device wins. Priority crosses the groups of eight devices in which the cascade is arranged.
- R2: On a hit, ram_hit is 1 and ram_addr equals {winner index (5 bits), winner's 17-bit local address}.
- R3: On a miss, ram_hit is 0 and ram_addr is 0. ram_drv_en selects the lowest-numbered device whose last-RAM flag is set, or device N-1 if no such flag is set.
- R4: On a hit, flag_drv_en selects the winner and flag_hit is 1. On a miss, flag_hit is 0 and flag_drv_en selects the lowest-numbered device whose last-device flag is set, or device N-1 if none is set.
- R5: In every cycle with ram_vld high, ram_drv_en has exactly one bit set. In every cycle with flag_vld high, flag_drv_en has exactly one bit set.
- R6: A command sampled at the end of cycle k gives ram_vld in cycle k+L. L is 4, 5 or 6 for device 0's table-size code 00, 01 or 10.
- R7: flag_vld rises in cycle k+L+H, where H is device 0's 3-bit hit-latency code (0 to 7).
- R8: cfg_err is 1 from the cycle after the inputs change whenever any device's table-size code or hit-latency code differs from device 0's.
- R9: cfg_err is 1 whenever the last-RAM mask or the last-device mask is anything other than device N-1 alone.
- R10: After reset all outputs are 0. Outside result cycles both drive-enable vectors are 0, and dev_hit has no effect while srch_cmd is low.
- R11: A new command may be issued in every cycle. Results come out in issue order with no loss.
- R12: Table-size code 11 raises cfg_err and is treated as latency 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| srch_cmd | input | 1 | Search command strobe; per-device results valid with it |
| dev_hit | input | N_DEV | Per-device hit flags |
| dev_laddr | input | N_DEV*LOC_W | Per-device local match addresses, device i at bits i*LOC_W |
| cfg_size | input | 2*N_DEV | Per-device table-size code |
| cfg_hlat | input | 3*N_DEV | Per-device hit-latency code |
| cfg_last_ram | input | N_DEV | Per-device last-RAM flag |
| cfg_last_dev | input | N_DEV | Per-device last-device flag |
| ram_vld | output | 1 | SRAM access cycle |
| ram_hit | output | 1 | Global hit in the SRAM access cycle |
| ram_addr | output | IDX_W+LOC_W | Global address |
| ram_drv_en | output | N_DEV | One-hot SRAM bus owner |
| flag_vld | output | 1 | Status flag cycle |
| flag_hit | output | 1 | Global hit flag |
| flag_drv_en | output | N_DEV | One-hot status flag owner |
| cfg_err | output | 1 | Cascade configuration error |

## Verification
The hardest case to reach is a miss under a faulty cascade setup, where the SRAM bus default and the status flag default land on different devices. Only then does the separation of the two default-driver rules show at the ports. The stimulus sets the last-device flag on a mid-chain device, then clears the last-RAM mask entirely, and issues misses under each setting. Priority across group boundaries is reached with hit patterns that straddle groups. Every latency tap is reached by sweeping the size and hit-latency codes with the pipeline drained between settings.

// File: rtl/cas_arb_pkg.sv
package cas_arb_pkg;
  localparam int unsigned MAX_LAT  = 6;
  localparam int unsigned MAX_HLAT = 7;
  localparam int unsigned GRP_W    = 8;

  typedef enum logic [1:0] {
    TS_SINGLE = 2'b00,
    TS_GROUP  = 2'b01,
    TS_FULL   = 2'b10,
    TS_RSVD   = 2'b11
  } tsize_e;

  // Result latency in cycles for a table-size code; the reserved code uses the longest
  function automatic int unsigned lat_of(input logic [1:0] code);
    case (tsize_e'(code))
      TS_SINGLE: return 4;
      TS_GROUP:  return 5;
      default:   return 6;
    endcase
  endfunction
endpackage

// File: rtl/cas_grp_prio.sv
module cas_grp_prio #(
  parameter  int W  = 8,
  localparam int IW = $clog2(W)
) (
  input  logic [W-1:0]  req,
  output logic          hit,
  output logic [IW-1:0] idx
);
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (req[i]) begin
        hit = 1'b1;
        idx = IW'(i);
      end
    end
  end

  // R1: the selected request is set and nothing below it is
  always_comb begin
    if (hit) begin
      a_r1_grp_lowest: assert (req[idx] && ((req & ((W'(1) << idx) - W'(1))) == '0));
    end
  end
endmodule

// File: rtl/cas_prio_tree.sv
module cas_prio_tree
  import cas_arb_pkg::*;
#(
  parameter  int N    = 31,
  localparam int IW   = $clog2(N),
  localparam int NG   = (N + GRP_W - 1) / GRP_W,
  localparam int PADW = NG * GRP_W,
  localparam int GIW  = $clog2(GRP_W)
) (
  input  logic [N-1:0]  req,
  output logic          hit,
  output logic [IW-1:0] idx
);
  logic [PADW-1:0] req_pad;
  logic [NG-1:0]   g_hit;
  logic [GIW-1:0]  g_idx [NG];

  assign req_pad = PADW'(req);

  for (genvar g = 0; g < NG; g++) begin : g_grp
    cas_grp_prio #(.W(GRP_W)) u_grp (
      .req (req_pad[g*GRP_W +: GRP_W]),
      .hit (g_hit[g]),
      .idx (g_idx[g])
    );
  end

  always_comb begin
    hit = |g_hit;
    idx = '0;
    for (int g = NG - 1; g >= 0; g--) begin
      if (g_hit[g]) idx = IW'(g * GRP_W + int'(g_idx[g]));
    end
  end
endmodule

// File: rtl/cas_cfg_check.sv
module cas_cfg_check #(
  parameter int N  = 31,
  parameter int IW = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [2*N-1:0]  cfg_size,
  input  logic [3*N-1:0]  cfg_hlat,
  input  logic [N-1:0]    cfg_last_ram,
  input  logic [N-1:0]    cfg_last_dev,
  output logic            err_q,
  output logic [1:0]      size_q,
  output logic [2:0]      hlat_q,
  output logic [IW-1:0]   ram_dflt_q,
  output logic [IW-1:0]   dev_dflt_q
);
  localparam logic [N-1:0] FINAL_MASK = {1'b1, {(N-1){1'b0}}};

  logic          mism;
  logic          err_d;
  logic [IW-1:0] ram_dflt_d;
  logic [IW-1:0] dev_dflt_d;

  function automatic logic [IW-1:0] first_or_final(input logic [N-1:0] m);
    logic [IW-1:0] r;
    r = IW'(N - 1);
    for (int i = N - 1; i >= 0; i--) if (m[i]) r = IW'(i);
    return r;
  endfunction

  always_comb begin
    mism = 1'b0;
    for (int i = 1; i < N; i++) begin
      if (cfg_size[2*i +: 2] != cfg_size[1:0]) mism = 1'b1;
      if (cfg_hlat[3*i +: 3] != cfg_hlat[2:0]) mism = 1'b1;
    end
    err_d = mism
          || (cfg_last_ram != FINAL_MASK)
          || (cfg_last_dev != FINAL_MASK)
          || (cfg_size[1:0] == 2'b11);
    ram_dflt_d = first_or_final(cfg_last_ram);
    dev_dflt_d = first_or_final(cfg_last_dev);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      err_q      <= 1'b0;
      size_q     <= 2'b10;
      hlat_q     <= 3'd0;
      ram_dflt_q <= IW'(N - 1);
      dev_dflt_q <= IW'(N - 1);
    end else begin
      err_q      <= err_d;
      size_q     <= cfg_size[1:0];
      hlat_q     <= cfg_hlat[2:0];
      ram_dflt_q <= ram_dflt_d;
      dev_dflt_q <= dev_dflt_d;
    end
  end

  // R9: a clean configuration leaves both defaults on the final device
  a_r9_clean_defaults: assert property (@(posedge clk) disable iff (rst)
    !err_q |-> (ram_dflt_q == IW'(N - 1)) && (dev_dflt_q == IW'(N - 1)));
  // R12: the reserved size code is always reported
  a_r12_rsvd_flagged: assert property (@(posedge clk) disable iff (rst)
    (size_q == 2'b11) |-> err_q);
endmodule

// File: rtl/cas_delay_line.sv
module cas_delay_line #(
  parameter int DEPTH = 11,
  parameter int PW    = 23
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_vld,
  input  logic [PW-1:0]             in_pay,
  output logic [DEPTH-1:0]          vld,
  output logic [DEPTH-1:0][PW-1:0]  pay
);
  // Valid bits are reset; payload is a plain shift chain with no reset
  always_ff @(posedge clk) begin
    if (rst) vld <= '0;
    else     vld <= {vld[DEPTH-2:0], in_vld};
  end

  always_ff @(posedge clk) begin
    pay <= {pay[DEPTH-2:0], in_pay};
  end
endmodule

// File: rtl/cas_result_arb.sv
module cas_result_arb
  import cas_arb_pkg::*;
#(
  parameter  int N_DEV = 31,
  parameter  int LOC_W = 17,
  localparam int IDX_W = $clog2(N_DEV),
  localparam int GA_W  = IDX_W + LOC_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    srch_cmd,
  input  logic [N_DEV-1:0]        dev_hit,
  input  logic [N_DEV*LOC_W-1:0]  dev_laddr,
  input  logic [2*N_DEV-1:0]      cfg_size,
  input  logic [3*N_DEV-1:0]      cfg_hlat,
  input  logic [N_DEV-1:0]        cfg_last_ram,
  input  logic [N_DEV-1:0]        cfg_last_dev,
  output logic                    ram_vld,
  output logic                    ram_hit,
  output logic [GA_W-1:0]         ram_addr,
  output logic [N_DEV-1:0]        ram_drv_en,
  output logic                    flag_vld,
  output logic                    flag_hit,
  output logic [N_DEV-1:0]        flag_drv_en,
  output logic                    cfg_err
);
  localparam int PW    = 1 + IDX_W + LOC_W;
  localparam int CHAIN = MAX_LAT + MAX_HLAT - 2;
  localparam int TW    = $clog2(CHAIN);
  localparam logic [N_DEV-1:0] ONE = {{(N_DEV-1){1'b0}}, 1'b1};

  // Stage 1: capture per-device results with the command
  logic                   cmd_q;
  logic [N_DEV-1:0]       hit_q;
  logic [N_DEV*LOC_W-1:0] laddr_q;

  always_ff @(posedge clk) begin
    if (rst) cmd_q <= 1'b0;
    else     cmd_q <= srch_cmd;
  end

  always_ff @(posedge clk) begin
    hit_q   <= dev_hit;
    laddr_q <= dev_laddr;
  end

  // Configuration checks and registered codes
  logic [1:0]       size_q;
  logic [2:0]       hlat_q;
  logic [IDX_W-1:0] ram_dflt;
  logic [IDX_W-1:0] dev_dflt;

  cas_cfg_check #(.N(N_DEV), .IW(IDX_W)) u_cfg (
    .clk          (clk),
    .rst          (rst),
    .cfg_size     (cfg_size),
    .cfg_hlat     (cfg_hlat),
    .cfg_last_ram (cfg_last_ram),
    .cfg_last_dev (cfg_last_dev),
    .err_q        (cfg_err),
    .size_q       (size_q),
    .hlat_q       (hlat_q),
    .ram_dflt_q   (ram_dflt),
    .dev_dflt_q   (dev_dflt)
  );

  // Priority encode, lowest device first
  logic             win_hit;
  logic [IDX_W-1:0] win_idx;
  logic [LOC_W-1:0] win_la;
  logic [PW-1:0]    win_pay;

  cas_prio_tree #(.N(N_DEV)) u_prio (
    .req (hit_q),
    .hit (win_hit),
    .idx (win_idx)
  );

  always_comb begin
    win_la  = win_hit ? laddr_q[int'(win_idx)*LOC_W +: LOC_W] : '0;
    win_pay = {win_hit, win_idx, win_la};
  end

  // Schedule chain; tap 0 is loaded two edges after the command
  logic [CHAIN-1:0]         c_vld;
  logic [CHAIN-1:0][PW-1:0] c_pay;

  cas_delay_line #(.DEPTH(CHAIN), .PW(PW)) u_dly (
    .clk    (clk),
    .rst    (rst),
    .in_vld (cmd_q),
    .in_pay (win_pay),
    .vld    (c_vld),
    .pay    (c_pay)
  );

  logic [TW-1:0]    ram_tap;
  logic [TW-1:0]    flag_tap;
  logic             r_v, f_v, r_h, f_h;
  logic [IDX_W-1:0] r_i, f_i;
  logic [LOC_W-1:0] r_la;

  always_comb begin
    ram_tap  = TW'(int'(lat_of(size_q)) - 3);
    flag_tap = TW'(int'(lat_of(size_q)) + int'(hlat_q) - 3);
    r_v  = c_vld[ram_tap];
    r_h  = c_pay[ram_tap][PW-1];
    r_i  = c_pay[ram_tap][PW-2 -: IDX_W];
    r_la = c_pay[ram_tap][LOC_W-1:0];
    f_v  = c_vld[flag_tap];
    f_h  = c_pay[flag_tap][PW-1];
    f_i  = c_pay[flag_tap][PW-2 -: IDX_W];
  end

  // Registered bus-owner outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      ram_vld     <= 1'b0;
      ram_hit     <= 1'b0;
      ram_addr    <= '0;
      ram_drv_en  <= '0;
      flag_vld    <= 1'b0;
      flag_hit    <= 1'b0;
      flag_drv_en <= '0;
    end else begin
      ram_vld     <= r_v;
      ram_hit     <= r_v && r_h;
      ram_addr    <= (r_v && r_h) ? {r_i, r_la} : '0;
      ram_drv_en  <= !r_v ? '0 : (r_h ? (ONE << r_i) : (ONE << ram_dflt));
      flag_vld    <= f_v;
      flag_hit    <= f_v && f_h;
      flag_drv_en <= !f_v ? '0 : (f_h ? (ONE << f_i) : (ONE << dev_dflt));
    end
  end

  // R5: exactly one owner in each result cycle
  a_r5_ram_onehot: assert property (@(posedge clk) disable iff (rst)
    ram_vld |-> $onehot(ram_drv_en));
  a_r5_flag_onehot: assert property (@(posedge clk) disable iff (rst)
    flag_vld |-> $onehot(flag_drv_en));
  // R10: no owner outside result cycles
  a_r10_ram_quiet: assert property (@(posedge clk) disable iff (rst)
    !ram_vld |-> (ram_drv_en == '0) && !ram_hit);
  a_r10_flag_quiet: assert property (@(posedge clk) disable iff (rst)
    !flag_vld |-> (flag_drv_en == '0) && !flag_hit);
  // R2: on a hit the bus owner is the device named in the address
  a_r2_owner_matches_addr: assert property (@(posedge clk) disable iff (rst)
    (ram_vld && ram_hit) |-> ram_drv_en[ram_addr[GA_W-1 -: IDX_W]]);
  // R3: with a clean setup a miss is driven by the final device
  a_r3_miss_final: assert property (@(posedge clk) disable iff (rst)
    (ram_vld && !ram_hit && !cfg_err && $stable(cfg_err)) |-> ram_drv_en[N_DEV-1]);
endmodule

// File: tb/test_cas_result_arb.sv
module test_cas_result_arb;
  localparam int N  = 31;
  localparam int LW = 17;
  localparam int IW = 5;
  localparam int GW = IW + LW;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic            rst;
  logic            srch_cmd;
  logic [N-1:0]    dev_hit;
  logic [N*LW-1:0] dev_laddr;
  logic [2*N-1:0]  cfg_size;
  logic [3*N-1:0]  cfg_hlat;
  logic [N-1:0]    cfg_last_ram;
  logic [N-1:0]    cfg_last_dev;
  logic            ram_vld, ram_hit, flag_vld, flag_hit, cfg_err;
  logic [GW-1:0]   ram_addr;
  logic [N-1:0]    ram_drv_en, flag_drv_en;

  cas_result_arb #(.N_DEV(N), .LOC_W(LW)) i_cas_result_arb (
    .clk(clk), .rst(rst), .srch_cmd(srch_cmd), .dev_hit(dev_hit),
    .dev_laddr(dev_laddr), .cfg_size(cfg_size), .cfg_hlat(cfg_hlat),
    .cfg_last_ram(cfg_last_ram), .cfg_last_dev(cfg_last_dev),
    .ram_vld(ram_vld), .ram_hit(ram_hit), .ram_addr(ram_addr),
    .ram_drv_en(ram_drv_en), .flag_vld(flag_vld), .flag_hit(flag_hit),
    .flag_drv_en(flag_drv_en), .cfg_err(cfg_err)
  );

  typedef struct { int due; logic hit; logic [GW-1:0] addr; logic [N-1:0] drv; } ram_exp_t;
  typedef struct { int due; logic hit; logic [N-1:0] drv; } flag_exp_t;

  ram_exp_t  rq[$];
  flag_exp_t fq[$];
  ram_exp_t  re;
  flag_exp_t fe;

  int cyc = 0;
  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  logic [1:0]   bsize [N];
  logic [2:0]   bhlat [N];
  logic [N-1:0] blram, bldev;
  localparam logic [N-1:0] FINAL = {1'b1, {(N-1){1'b0}}};
  localparam logic [N-1:0] ONE   = {{(N-1){1'b0}}, 1'b1};

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int exp_lat(input logic [1:0] c);
    if (c == 2'b00) return 4;
    if (c == 2'b01) return 5;
    return 6;
  endfunction

  function automatic int first_or_last(input logic [N-1:0] m);
    for (int i = 0; i < N; i++) if (m[i]) return i;
    return N - 1;
  endfunction

  task automatic set_all(input logic [1:0] s, input logic [2:0] h);
    for (int i = 0; i < N; i++) begin bsize[i] = s; bhlat[i] = h; end
    blram = FINAL;
    bldev = FINAL;
  endtask

  task automatic apply_cfg();
    for (int i = 0; i < N; i++) begin
      cfg_size[2*i +: 2] = bsize[i];
      cfg_hlat[3*i +: 3] = bhlat[i];
    end
    cfg_last_ram = blram;
    cfg_last_dev = bldev;
  endtask

  function automatic logic exp_err();
    logic e;
    e = (blram != FINAL) || (bldev != FINAL) || (bsize[0] == 2'b11);
    for (int i = 1; i < N; i++)
      if (bsize[i] != bsize[0] || bhlat[i] != bhlat[0]) e = 1'b1;
    return e;
  endfunction

  task automatic search(input logic [N-1:0] hits, input int seed);
    int w, l, h;
    ram_exp_t  r;
    flag_exp_t f;
    @(negedge clk);
    srch_cmd = 1'b1;
    dev_hit  = hits;
    for (int i = 0; i < N; i++) dev_laddr[i*LW +: LW] = LW'(seed * 37 + i * 1031);
    w = -1;
    for (int i = N - 1; i >= 0; i--) if (hits[i]) w = i;
    l = exp_lat(bsize[0]);
    h = int'(bhlat[0]);
    r.due = cyc + l;
    f.due = cyc + l + h;
    r.hit = (w >= 0);
    f.hit = (w >= 0);
    if (w >= 0) begin
      r.addr = {IW'(w), dev_laddr[w*LW +: LW]};
      r.drv  = ONE << w;
      f.drv  = ONE << w;
    end else begin
      r.addr = '0;
      r.drv  = ONE << first_or_last(blram);
      f.drv  = ONE << first_or_last(bldev);
    end
    rq.push_back(r);
    fq.push_back(f);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      srch_cmd = 1'b0;
      dev_hit  = '1;
    end
  endtask

  task automatic drain();
    idle(20);
    check("R11 results all delivered (ram)", rq.size(), 0);
    check("R11 results all delivered (flag)", fq.size(), 0);
  endtask

  task automatic reconfig(input string tag);
    apply_cfg();
    idle(3);
    check(tag, cfg_err, exp_err());
  endtask

  // Monitor: scoreboard pops expected items as results appear
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (ram_vld) begin
        check("R5 ram owner one-hot", $countones(ram_drv_en), 1);
        if (rq.size() == 0) check("R10 unexpected ram result", 1, 0);
        else begin
          re = rq.pop_front();
          check("R6 ram result cycle", cyc, re.due);
          check("R3 ram_hit", ram_hit, re.hit);
          check("R1 R2 ram_addr", ram_addr, re.addr);
          check("R1 R3 ram_drv_en", ram_drv_en, re.drv);
        end
      end else begin
        if (ram_drv_en != '0) check("R10 ram_drv_en idle", ram_drv_en, 0);
        if (rq.size() > 0 && rq[0].due < cyc) begin
          check("R6 ram result missing", 0, 1);
          void'(rq.pop_front());
        end
      end
      if (flag_vld) begin
        check("R5 flag owner one-hot", $countones(flag_drv_en), 1);
        if (fq.size() == 0) check("R10 unexpected flag result", 1, 0);
        else begin
          fe = fq.pop_front();
          check("R7 flag cycle", cyc, fe.due);
          check("R4 flag_hit", flag_hit, fe.hit);
          check("R4 flag_drv_en", flag_drv_en, fe.drv);
        end
      end else begin
        if (flag_drv_en != '0) check("R10 flag_drv_en idle", flag_drv_en, 0);
        if (fq.size() > 0 && fq[0].due < cyc) begin
          check("R7 flag result missing", 0, 1);
          void'(fq.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    rst = 1'b1;
    srch_cmd = 1'b0;
    dev_hit = '0;
    dev_laddr = '0;
    set_all(2'b01, 3'd1);
    apply_cfg();
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: reset state
    check("R10 reset ram_vld", ram_vld, 0);
    check("R10 reset flag_vld", flag_vld, 0);
    check("R10 reset ram_drv_en", ram_drv_en, 0);
    check("R10 reset flag_drv_en", flag_drv_en, 0);
    check("R10 reset ram_addr", ram_addr, 0);
    check("R8 R9 clean config", cfg_err, 0);

    // R1 R2 R3 R4: basic patterns, size 01, hit latency 1
    search(ONE << 5, 1);  idle(8);
    search('0, 2);        idle(8);
    search((ONE << 3) | (ONE << 20) | (ONE << 30), 3); idle(8);
    search((ONE << 9) | (ONE << 17), 4); idle(8);   // R1 across groups
    search(ONE << 30, 5); idle(8);
    search('1, 6);        idle(8);
    idle(4);
    check("R10 no result without command", rq.size(), 0);
    drain();

    // R11: back-to-back commands
    search(ONE << 7, 10); search('0, 11); search(ONE << 24, 12);
    search((ONE << 15) | (ONE << 16), 13); search('0, 14); search(ONE << 0, 15);
    drain();

    // R6 R7: latency and flag shift sweep
    set_all(2'b00, 3'd0); reconfig("R6 size 00 clean");
    search(ONE << 2, 20); search('0, 21); drain();
    set_all(2'b10, 3'd7); reconfig("R6 size 10 clean");
    search(ONE << 28, 22); search('0, 23); drain();
    set_all(2'b01, 3'd4); reconfig("R7 hlat 4 clean");
    search(ONE << 11, 24); drain();

    // R12: reserved size code
    set_all(2'b11, 3'd2); reconfig("R12 reserved size code error");
    search(ONE << 6, 25); drain();

    // R8: mismatched codes
    set_all(2'b01, 3'd1); bhlat[12] = 3'd3; reconfig("R8 hit-latency mismatch error");
    set_all(2'b01, 3'd1); bsize[29] = 2'b10; reconfig("R8 size mismatch error");

    // R9 R4: default flags off the final device
    set_all(2'b01, 3'd1); bldev = ONE << 4; reconfig("R9 last-device misplaced error");
    search('0, 30); search(ONE << 8, 31); drain();
    set_all(2'b01, 3'd1); blram = '0; reconfig("R9 last-RAM missing error");
    search('0, 32); drain();
    set_all(2'b01, 3'd1); blram = FINAL | (ONE << 1); reconfig("R9 two last-RAM flags error");
    search('0, 33); drain();

    set_all(2'b01, 3'd1); reconfig("R9 restored clean");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule